// File: doc/BRIEF.md
# Debug Breakpoint Controller

This block holds the debug control byte and the breakpoint logic that sits next to a small 8-bit processor. A host writes and reads it through an 8-bit register port. The processor supplies three inputs: a strobe when it decodes the break opcode, a strobe for each completed instruction, and its program counter. The block returns a halt signal that stops instruction fetch and a loop signal that keeps the processor on the break instruction.

A 16-bit register serves two purposes. It is either an instruction down-counter or the address of a hardware breakpoint on the program counter. When a breakpoint stops the processor, the block can offer the acknowledge byte FFH to a serial transmitter. The offer uses a valid/ready handshake, and the request disarms itself once the byte has been taken. Writing the low control bit produces a one-cycle reset request pulse.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset, all three registers (address 0 control, address 1 counter high byte, address 2 counter low byte) read 00H. halt_o, loop_o, ack_valid and rst_req_o are all 0.
- R2: With the break-enable bit (control bit 6) at 0, a break strobe has no effect. halt_o stays unchanged.
- R3: With break-enable at 1 and loop-mode (bit 4) at 0, a break strobe sets the halt bit (bit 7). halt_o is 1 from the next clock edge onward.
- R4: halt_o follows control bit 7. Writing the bit to 0 lets the processor run again, and writing it to 1 halts it.
- R5: With break-enable at 1 and loop-mode at 1, loop_o equals the break strobe in the same cycle, and the halt bit is not set.
- R6: With the PC-match bit (bit 3) at 1, the halt bit is set at the edge after pc equals the counter register.
- R7: While the PC-match bit is 1, instruction strobes leave the counter register unchanged.
- R8: While the PC-match bit is 0 and the processor is not halted, each instruction strobe decrements the counter by one, wrapping from 0000H to FFFFH. While halted, the counter holds its value.
- R9: If the acknowledge-enable bit (bit 5) is 1 when a breakpoint sets the halt bit, ack_valid rises with ack_data = FFH. It stays high until ack_ready is seen. On that edge it drops and bit 5 clears.
- R10: A breakpoint that sets the halt bit wins over a control write that clears it in the same cycle.
- R11: Control bits 2, 1 and 0 always read as 0. Address 3 reads 00H.
- R12: A control write with bit 0 set gives rst_req_o high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 counter high, 2 counter low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| brk_dec | input | 1 | Break opcode decoded this cycle |
| instr_step | input | 1 | One instruction completed this cycle |
| pc | input | 16 | Current program counter |
| halt_o | output | 1 | Stop instruction fetch |
| loop_o | output | 1 | Hold the processor on the break instruction |
| rst_req_o | output | 1 | One-cycle reset request |
| ack_valid | output | 1 | Acknowledge byte offered |
| ack_data | output | 8 | Acknowledge byte |
| ack_ready | input | 1 | Transmitter takes the byte |

## Verification
The break strobe is applied under each of the three settings of the enable and loop bits. A correct design gives three different outcomes: no effect, halt, or loop with no halt. The counter is stepped in three conditions (running with matching off, halted, and matching armed), which tells decrementing apart from freezing. It is also stepped from zero to show the wrap. Further runs cover the acknowledge with ready held low and then raised, a clearing write that collides with a break, and a write of only the low three control bits. Together these confirm the handshake order, the set-over-clear priority, and the reserved and pulse bits.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int unsigned BYTE_W = 8;

  // control byte bit positions
  localparam int unsigned B_HALT  = 7;
  localparam int unsigned B_BRKEN = 6;
  localparam int unsigned B_ACKEN = 5;
  localparam int unsigned B_LOOP  = 4;
  localparam int unsigned B_PCM   = 3;
  localparam int unsigned B_RSTRQ = 0;

  typedef struct packed {
    logic halt;
    logic brken;
    logic acken;
    logic loop;
    logic pcm;
  } ctl_t;
endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  ctl_t wfield,
  input  logic set_halt,
  input  logic ack_done,
  output ctl_t q
);
  ctl_t d;
  logic en;

  always_comb begin
    d = q;
    if (wr)       d = wfield;
    if (set_halt) d.halt = 1'b1;
    if (ack_done) d.acken = 1'b0;
  end

  assign en = wr | set_halt | ack_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dbg_bp_cnt.sv
module dbg_bp_cnt #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W/BYTE_W-1:0] byte_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dec_en,
  input  logic [CNT_W-1:0]  pc,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              pc_match
);
  localparam int unsigned NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] dec_val;
  logic             en;

  always_comb begin
    dec_val = cnt_q - CNT_W'(1);
    cnt_d   = dec_en ? dec_val : cnt_q;
    for (int i = 0; i < NB; i++) begin
      if (byte_wr[i]) cnt_d[i*BYTE_W +: BYTE_W] = wdata;
    end
  end

  assign en       = dec_en | (|byte_wr);
  assign pc_match = (pc == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dbg_ack_tx.sv
module dbg_ack_tx #(
  parameter int unsigned BYTE_W = 8,
  parameter logic [BYTE_W-1:0] ACK_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              ready,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  output logic              done
);
  logic              valid_d;
  logic [BYTE_W-1:0] data_d;

  assign done = valid & ready;

  always_comb begin
    valid_d = valid;
    data_d  = data;
    if (done) valid_d = 1'b0;
    if (req && !valid) begin
      valid_d = 1'b1;
      data_d  = ACK_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= valid_d;
      data  <= data_d;
    end
  end

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data))); // R9
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              brk_dec,
  input  logic              instr_step,
  input  logic [CNT_W-1:0]  pc,
  output logic              halt_o,
  output logic              loop_o,
  output logic              rst_req_o,
  output logic              ack_valid,
  output logic [BYTE_W-1:0] ack_data,
  input  logic              ack_ready
);
  localparam int unsigned NB = CNT_W / BYTE_W;

  ctl_t ctl;
  ctl_t wfield;
  logic ctl_wr;
  logic [NB-1:0] byte_wr;
  logic [CNT_W-1:0] cnt;
  logic pc_match, pc_hit, brk_set, set_halt, ack_done, dec_en, rst_d;
  logic unused_wbits;

  assign ctl_wr = reg_wr && (reg_addr == '0);
  assign unused_wbits = ^reg_wdata[2:1];

  // counter bytes: address 1 is the most significant byte
  for (genvar g = 0; g < NB; g++) begin : g_bwr
    assign byte_wr[g] = reg_wr && (reg_addr == ADDR_W'(NB - g));
  end

  assign wfield = '{halt:  reg_wdata[B_HALT],  brken: reg_wdata[B_BRKEN],
                    acken: reg_wdata[B_ACKEN], loop:  reg_wdata[B_LOOP],
                    pcm:   reg_wdata[B_PCM]};

  assign brk_set  = brk_dec && ctl.brken && !ctl.loop && !ctl.halt;
  assign pc_hit   = ctl.pcm && pc_match && !ctl.halt;
  assign set_halt = brk_set | pc_hit;
  assign dec_en   = instr_step && !ctl.pcm && !ctl.halt;
  assign loop_o   = brk_dec && ctl.brken && ctl.loop;
  assign halt_o   = ctl.halt;
  assign rst_d    = ctl_wr && reg_wdata[B_RSTRQ];

  dbg_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wfield(wfield),
    .set_halt(set_halt), .ack_done(ack_done), .q(ctl)
  );

  dbg_bp_cnt #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .wdata(reg_wdata),
    .dec_en(dec_en), .pc(pc), .cnt_q(cnt), .pc_match(pc_match)
  );

  dbg_ack_tx #(.BYTE_W(BYTE_W), .ACK_BYTE('1)) u_ack (
    .clk(clk), .rst_n(rst_n), .req(set_halt && ctl.acken),
    .ready(ack_ready), .valid(ack_valid), .data(ack_data), .done(ack_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_o <= 1'b0;
    else        rst_req_o <= rst_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata[B_HALT]  = ctl.halt;
      reg_rdata[B_BRKEN] = ctl.brken;
      reg_rdata[B_ACKEN] = ctl.acken;
      reg_rdata[B_LOOP]  = ctl.loop;
      reg_rdata[B_PCM]   = ctl.pcm;
    end
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(NB - i)) reg_rdata = cnt[i*BYTE_W +: BYTE_W];
    end
  end

  AST_BRK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_dec && !ctl.brken && !ctl_wr && !pc_hit) |=> (halt_o == $past(halt_o))); // R2
  AST_BRK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_dec && ctl.brken && !ctl.loop) |=> halt_o); // R3
  AST_LOOP_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_dec && ctl.brken && ctl.loop && !halt_o && !pc_hit && !ctl_wr) |=> !halt_o); // R5
  AST_PC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pcm && pc == cnt) |=> halt_o); // R6
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pcm && !(|byte_wr)) |=> $stable(cnt)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_halt && ctl_wr && !reg_wdata[B_HALT]) |=> halt_o); // R10
endmodule

// File: tb/tb_dbg_brk_ctrl.sv
module tb_dbg_brk_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       brk_dec, instr_step, ack_ready;
  logic [15:0] pc;
  logic       halt_o, loop_o, rst_req_o, ack_valid;
  logic [7:0] ack_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_brk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_dec(brk_dec),
    .instr_step(instr_step), .pc(pc), .halt_o(halt_o), .loop_o(loop_o),
    .rst_req_o(rst_req_o), .ack_valid(ack_valid), .ack_data(ack_data),
    .ack_ready(ack_ready)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
    reg_addr = 2'd0;
  endtask

  task automatic brk_pulse();
    brk_dec = 1'b1;
    @(negedge clk);
    brk_dec = 1'b0;
  endtask

  task automatic steps(int n);
    instr_step = 1'b1;
    repeat (n) @(negedge clk);
    instr_step = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 2'd0, 8'h00);
    rd_chk("R1 cnt hi", 2'd1, 8'h00);
    rd_chk("R1 cnt lo", 2'd2, 8'h00);
    chk("R1 halt", halt_o, 0);
    chk("R1 loop", loop_o, 0);
    chk("R1 valid", ack_valid, 0);
    chk("R1 rstreq", rst_req_o, 0);
  endtask

  task automatic t_nop();
    wr(2'd0, 8'h00);
    brk_pulse();
    chk("R2 halt", halt_o, 0);
    rd_chk("R2 ctrl", 2'd0, 8'h00);
  endtask

  task automatic t_halt();
    wr(2'd0, 8'h40);
    brk_pulse();
    chk("R3 halt", halt_o, 1);
    rd_chk("R3 ctrl", 2'd0, 8'hC0);
    wr(2'd0, 8'h40);
    chk("R4 resume", halt_o, 0);
    wr(2'd0, 8'hC0);
    chk("R4 halt by write", halt_o, 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_loop();
    wr(2'd0, 8'h50);
    brk_dec = 1'b1;
    #1;
    chk("R5 loop on", loop_o, 1);
    @(negedge clk);
    brk_dec = 1'b0;
    #1;
    chk("R5 loop off", loop_o, 0);
    chk("R5 no halt", halt_o, 0);
    wr(2'd0, 8'h00);
    brk_dec = 1'b1;
    #1;
    chk("R5 loop needs enable", loop_o, 0);
    @(negedge clk);
    brk_dec = 1'b0;
  endtask

  task automatic t_cnt();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h05);
    steps(3);
    rd_chk("R8 decrement", 2'd2, 8'h02);
    rd_chk("R8 hi", 2'd1, 8'h00);
    wr(2'd0, 8'h80);
    steps(2);
    rd_chk("R8 hold halted", 2'd2, 8'h02);
    wr(2'd0, 8'h08);
    steps(3);
    rd_chk("R7 frozen", 2'd2, 8'h02);
    chk("R6 no early halt", halt_o, 0);
    pc = 16'h0002;
    @(negedge clk);
    chk("R6 pc halt", halt_o, 1);
    rd_chk("R6 ctrl", 2'd0, 8'h88);
    pc = 16'h1234;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    steps(1);
    rd_chk("R8 wrap hi", 2'd1, 8'hFF);
    rd_chk("R8 wrap lo", 2'd2, 8'hFF);
  endtask

  task automatic t_prio();
    wr(2'd0, 8'h40);
    brk_dec = 1'b1;
    wr(2'd0, 8'h40);
    brk_dec = 1'b0;
    chk("R10 set wins", halt_o, 1);
    wr(2'd0, 8'h40);
    chk("R10 plain clear", halt_o, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ack();
    ack_ready = 1'b0;
    wr(2'd0, 8'h60);
    chk("R9 idle", ack_valid, 0);
    brk_pulse();
    chk("R9 valid", ack_valid, 1);
    chk("R9 data", ack_data, 8'hFF);
    chk("R9 halt", halt_o, 1);
    repeat (3) @(negedge clk);
    chk("R9 held", ack_valid, 1);
    rd_chk("R9 enable kept", 2'd0, 8'hE0);
    ack_ready = 1'b1;
    @(negedge clk);
    ack_ready = 1'b0;
    chk("R9 dropped", ack_valid, 0);
    rd_chk("R9 enable cleared", 2'd0, 8'hC0);
    wr(2'd0, 8'h40);
    brk_pulse();
    chk("R9 no second ack", ack_valid, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_rsv();
    wr(2'd0, 8'h07);
    chk("R12 pulse", rst_req_o, 1);
    rd_chk("R11 reserved", 2'd0, 8'h00);
    @(negedge clk);
    chk("R12 one cycle", rst_req_o, 0);
    rd_chk("R11 addr3", 2'd3, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
    brk_dec = 0; instr_step = 0; ack_ready = 0; pc = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nop();
    t_halt();
    t_loop();
    t_cnt();
    t_prio();
    t_ack();
    t_rsv();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule